// File: doc/BRIEF.md
# Bidirectional Latched and Clocked Bus Transceiver

This block joins two 18-bit ports, A and B, with one storage element for each direction. Each direction has three controls: a latch enable, a capture strobe and an output enable. With the latch enable high, the storage element is transparent and the far port follows the near port in the same cycle. With the latch enable low, the element holds its value. It loads new data only on a rising transition of its capture strobe. The output enable of the A-to-B direction is active high and the one for B-to-A is active low.

Each port is split into an input, an input-valid flag, an output and an output-enable flag. A low valid flag means nobody drives that side of the bus. A bus-hold register then supplies the last value seen while the flag was high, so the input never floats.

The data ports carry a valid qualifier but no ready. A bus cannot stall, so there is no back-pressure: a low valid flag selects the held value and never delays data.

The capture strobes are level inputs sampled on the system clock `clk`. A rising transition is the first `clk` edge at which a strobe is seen high after it was seen low at the previous edge.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: After reset, both storage elements and both bus-hold registers are zero. With the latch enables low and both outputs enabled, `a_out` and `b_out` read zero.
- R2: While `ab_le` is high and `ab_oe` is high, `b_out` equals the effective A input in the same cycle, with no clock edge needed.
- R3: While `ab_le` is low and no rising transition of `ab_clk` is seen, `b_out` keeps its value whatever `a_in` does. A falling transition of `ab_clk` has no effect.
- R4: While `ab_le` is low, a rising transition of `ab_clk` at a `clk` edge loads the effective A input present at that edge. `b_out` shows the new value right after that edge.
- R5: When `ab_le` falls, the element keeps the effective A input from the last `clk` edge at which `ab_le` was high.
- R6: `b_oe` follows `ab_oe` (active high). While `b_oe` is low, `b_out` reads zero, and the storage element still loads and keeps data.
- R7: The B-to-A direction behaves like R2 to R6, using `ba_le` and `ba_clk`. Its enable `ba_oe_n` is active low: `a_oe` is the inverse of `ba_oe_n`, and `a_out` reads zero while `a_oe` is low.
- R8: The effective input of a port is `x_in` while `x_valid` is high. While `x_valid` is low, it is the `x_in` value from the last `clk` edge at which `x_valid` was high (zero if there was none since reset).
- R9: A rising transition of a capture strobe while its latch enable is high has no effect beyond transparency: the output still equals the effective input.
- R10: The two directions store data independently. Both output enables may be active at once without changing either stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | Value seen on the A side |
| a_valid | input | 1 | A side is actively driven |
| a_out | output | 18 | Value this block drives onto A |
| a_oe | output | 1 | This block drives A |
| b_in | input | 18 | Value seen on the B side |
| b_valid | input | 1 | B side is actively driven |
| b_out | output | 18 | Value this block drives onto B |
| b_oe | output | 1 | This block drives B |
| ab_le | input | 1 | A-to-B latch enable, high is transparent |
| ab_clk | input | 1 | A-to-B capture strobe, rising transition loads |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high is transparent |
| ba_clk | input | 1 | B-to-A capture strobe, rising transition loads |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Transparent results and output-enable changes are combinational, so they are due in the same cycle as the stimulus. Captures through a strobe, latch closure and bus-hold fallback pass through one register, so they are due just after the first `clk` edge that sees the stimulus. The bench changes inputs on the falling edge and samples two nanoseconds after the next rising edge. That single sample point therefore covers both the combinational results and the one-register results. The bench also counts every sample at which a side is driven from both ends, and it requires that count to stay zero.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  // how a direction's storage element treats this cycle
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic         pin_valid,
  output logic [W-1:0] eff_out
);
  logic [W-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         keep_q <= '0;
    else if (pin_valid) keep_q <= pin_in;
  end

  // driven side wins; otherwise the last driven value is replayed
  assign eff_out = pin_valid ? pin_in : keep_q;
endmodule

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = 18,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         strobe,
  input  logic         oe_pin,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic         strobe_rise;
  logic         oe_act;
  store_mode_e  mode;
  logic [W-1:0] store_q;
  logic [W-1:0] shown;

  xcvr_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (strobe),
    .rise  (strobe_rise)
  );

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe_act = ~oe_pin;
    end else begin : g_oe_high
      assign oe_act = oe_pin;
    end
  endgenerate

  // transparency overrides the strobe
  always_comb begin
    if (le)               mode = MODE_PASS;
    else if (strobe_rise) mode = MODE_CAPTURE;
    else                  mode = MODE_HOLD;
  end

  // while transparent the element tracks its input each edge, so a
  // falling latch enable keeps the value from the last open edge
  always_ff @(posedge clk) begin
    if (!rst_n)                store_q <= '0;
    else if (mode != MODE_HOLD) store_q <= din;
  end

  assign shown = (mode == MODE_PASS) ? din : store_q;
  assign dout  = oe_act ? shown : '0;
  assign oe    = oe_act;
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_valid,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_valid,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n
);
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;

  xcvr_bus_hold #(.W(W)) u_hold_a (
    .clk(clk), .rst_n(rst_n), .pin_in(a_in), .pin_valid(a_valid), .eff_out(a_eff)
  );

  xcvr_bus_hold #(.W(W)) u_hold_b (
    .clk(clk), .rst_n(rst_n), .pin_in(b_in), .pin_valid(b_valid), .eff_out(b_eff)
  );

  xcvr_path #(.W(W), .OE_LOW(1'b0)) u_path_ab (
    .clk(clk), .rst_n(rst_n), .din(a_eff), .le(ab_le), .strobe(ab_clk),
    .oe_pin(ab_oe), .dout(b_out), .oe(b_oe)
  );

  xcvr_path #(.W(W), .OE_LOW(1'b1)) u_path_ba (
    .clk(clk), .rst_n(rst_n), .din(b_eff), .le(ba_le), .strobe(ba_clk),
    .oe_pin(ba_oe_n), .dout(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         a_valid,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic         b_valid,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_oe_n
);
  AST_PASS_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && ab_oe && a_valid) |-> (b_out == a_in)); // R2

  AST_HOLD_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(!ab_le) && ab_oe && $past(ab_oe) && $past(rst_n) &&
     !($past(ab_clk) && !$past(ab_clk, 2))) |-> $stable(b_out)); // R3

  AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!ab_le) && $past(ab_clk) && !$past(ab_clk, 2) &&
     $past(a_valid) && !ab_le && ab_oe) |-> (b_out == $past(a_in))); // R4

  AST_OFF_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_out == '0)); // R6

  AST_PASS_BA: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_le && !ba_oe_n && b_valid) |-> (a_out == b_in)); // R7

  AST_HOLD_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && ab_oe && !a_valid && $past(a_valid) && $past(rst_n))
      |-> (b_out == $past(a_in))); // R8
endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_valid(a_valid), .a_out(a_out),
  .b_in(b_in), .b_valid(b_valid), .b_out(b_out), .b_oe(b_oe),
  .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe), .ba_le(ba_le), .ba_oe_n(ba_oe_n)
);

// File: tb/test_bidir_reg_xcvr.sv
module test_bidir_reg_xcvr;
  localparam int W = 18;

  typedef struct packed {
    logic [W-1:0] a;
    logic         v;
    logic         le;
    logic         ck;
    logic         oe;
    logic [W-1:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{18'h12345, 1'b1, 1'b1, 1'b0, 1'b1, 18'h12345}, // R2 transparent
    '{18'h3FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 18'h12345}, // R5 latch closed
    '{18'h00ABC, 1'b1, 1'b0, 1'b0, 1'b1, 18'h12345}, // R3 held
    '{18'h00ABC, 1'b1, 1'b0, 1'b1, 1'b1, 18'h00ABC}, // R4 rising capture
    '{18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 18'h00ABC}, // R3 strobe stays high
    '{18'h15555, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00ABC}, // R3 falling strobe
    '{18'h15555, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00000}, // R6 disabled
    '{18'h15555, 1'b1, 1'b0, 1'b1, 1'b0, 18'h00000}, // R6 capture while off
    '{18'h33333, 1'b1, 1'b0, 1'b1, 1'b1, 18'h15555}, // R6 kept through off
    '{18'h0F0F0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h33333}, // R8 hold fallback
    '{18'h0F0F0, 1'b0, 1'b0, 1'b1, 1'b1, 18'h33333}, // R8 capture held value
    '{18'h01111, 1'b1, 1'b1, 1'b0, 1'b1, 18'h01111}, // R2 transparent again
    '{18'h02222, 1'b1, 1'b1, 1'b1, 1'b1, 18'h02222}, // R9 strobe while open
    '{18'h03333, 1'b1, 1'b0, 1'b1, 1'b1, 18'h02222}  // R9 no late capture
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         a_valid = 1'b0, b_valid = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b1;
  logic         ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b0;

  int checks = 0;
  int errors = 0;
  int clashes = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_reg_xcvr #(.W(W)) i_bidir_reg_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_valid(a_valid), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_valid(b_valid), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n)
  );

  // a side driven from both ends at a sample point
  always @(negedge clk) begin
    if (rst_n && ((a_oe && a_valid) || (b_oe && b_valid))) clashes++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 b_out", 32'(b_out), 32'h0);
    chk("R1 a_out", 32'(a_out), 32'h0);

    @(negedge clk);
    ba_oe_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_in = VECS[i].a;  a_valid = VECS[i].v;
      ab_le = VECS[i].le; ab_clk = VECS[i].ck; ab_oe = VECS[i].oe;
      step();
      chk($sformatf("vector %0d b_out", i), 32'(b_out), 32'(VECS[i].exp));
      chk($sformatf("vector %0d b_oe (R6)", i), 32'(b_oe), 32'(VECS[i].oe));
    end

    // R7: B-to-A transparent, then disabled
    @(negedge clk);
    ab_oe = 1'b0; a_valid = 1'b0;
    b_in = 18'h2468A; b_valid = 1'b1; ba_le = 1'b1; ba_oe_n = 1'b1;
    step();
    chk("R7 a_oe off", 32'(a_oe), 32'h0);
    chk("R7 a_out off", 32'(a_out), 32'h0);
    @(negedge clk);
    b_valid = 1'b0; ba_oe_n = 1'b0;
    step();
    chk("R7 a_oe on", 32'(a_oe), 32'h1);
    chk("R7 transparent via hold", 32'(a_out), 32'h2468A);
    // R7: capture on rising strobe
    @(negedge clk);
    ba_oe_n = 1'b1; ba_le = 1'b0; b_in = 18'h01357; b_valid = 1'b1;
    step();
    @(negedge clk);
    ba_clk = 1'b1;
    step();
    @(negedge clk);
    b_in = 18'h3C3C3; b_valid = 1'b0; ba_oe_n = 1'b0;
    step();
    chk("R7 captured", 32'(a_out), 32'h01357);

    // R10: both enables on, both held, sides undriven
    @(negedge clk);
    ab_oe = 1'b1; ab_le = 1'b0; a_in = 18'h3FFFF; a_valid = 1'b0;
    step();
    step();
    chk("R10 b_out kept", 32'(b_out), 32'h02222);
    chk("R10 a_out kept", 32'(a_out), 32'h01357);
    chk("R10 b_oe", 32'(b_oe), 32'h1);
    chk("R10 a_oe", 32'(a_oe), 32'h1);
    chk("R10 no contention", 32'(clashes), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule